// File: doc/BRIEF.md
# Instruction Prefix Scanner and Operand/Address Size Resolver

This block sits at the front of an x86 instruction decoder. It takes instruction bytes one per cycle over a valid/ready handshake, together with a 2-bit decoding mode that selects 16-, 32- or 64-bit operation. It consumes every prefix byte until it reaches the first opcode byte. It then presents one result record and holds it until the next stage acknowledges it. The record carries the opcode byte, the lock/repeat choice and segment override that were kept, the REX fields, any mandatory prefix and the effective operand and address sizes.

Prefix bytes are handled in a deferred way. The most recent legacy-class byte stays pending until the next byte arrives. If that next byte is another prefix, the pending byte is applied with its normal meaning. If it is the opcode and the pending byte is 66, F2 or F3, the pending byte is reported as a mandatory prefix and is not applied. In 64-bit mode a REX byte may sit between that pending byte and the opcode. A REX byte is kept only when the opcode follows it directly. While the record is held, two opcode-dependent hints from downstream (byte operation, promoted to 64 bits) are applied combinationally to the operand size.

The controller has two states. SCAN accepts bytes (`in_ready` high). It moves to HOLD when an opcode byte is accepted, or when a prefix byte would exceed the prefix length limit. HOLD presents the record (`out_valid` high) and returns to SCAN on `out_ack`, clearing all gathered prefix state.

Top module: `prefix_size_resolver`

## Requirements
- R1: After reset `in_ready`=1 and `out_valid`=0. The cycle after an opcode byte is accepted, `out_valid` is 1 and `in_ready` is 0. All result outputs stay unchanged until `out_ack` is seen, and the following cycle `in_ready` is 1 again.
- R2: Lock/repeat group: `out_lockrep` is 0 none, 1 for F0, 2 for F3, 3 for F2. Only one member is kept, and the last one applied wins.
- R3: Segment override: `out_seg` is 0 none, 1 ES(26), 2 CS(2E), 3 SS(36), 4 DS(3E), 5 FS(64), 6 GS(65). The last one applied wins.
- R4: In 64-bit mode (mode 2) the bytes 26, 2E, 36 and 3E have no effect on `out_seg`, while 64 and 65 still apply.
- R5: A 66, F2 or F3 that is the last legacy byte before the opcode is reported on `out_mand` (1=66, 2=F3, 3=F2) and is not applied with its legacy meaning. REX bytes may come between it and the opcode.
- R6: Only in mode 2 is a byte 40..4F a REX prefix. `out_rex_wrxb` holds its low nibble (bit 3 W, bit 2 R, bit 1 X, bit 0 B), and `out_rex_present` is 1 even for 40. A REX followed by a legacy byte is discarded. In modes 0 and 1 these bytes are opcodes.
- R7: Operand size (`out_opsize` 0=8, 1=16, 2=32, 3=64) in mode 0 is 16, or 32 with an applied 66. In mode 1 it is 32, or 16 with an applied 66.
- R8: In mode 2 the operand size is 32, or 16 with an applied 66. REX.W=1 or the promote hint gives 64 and then 66 has no effect.
- R9: Address size (`out_adsize`, same coding) is 16 in mode 0, 32 in mode 1 and 64 in mode 2. An applied 67 switches 16 and 32 to each other, and 64 to 32.
- R10: With `hint_byte_op`=1 the operand size is 8, whatever 66 or REX.W say.
- R11: A legacy prefix value that appears twice before the opcode sets `out_err_dup`.
- R12: More than MAX_LEGACY legacy-class bytes (mandatory ones included) before the opcode sets `out_err_count`. Exactly MAX_LEGACY does not set it.
- R13: A prefix byte arriving after MAX_PREFIX_BYTES prefix bytes ends the scan. The record then has `out_err_len`=1, that byte as the opcode, and all gathered prefix state cleared. Scanning restarts cleanly after the acknowledge. Exactly MAX_PREFIX_BYTES prefixes followed by an opcode is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Decoding mode: 0=16-bit, 1=32-bit, 2=64-bit |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Result record valid |
| out_ack | input | 1 | Downstream takes the record |
| hint_byte_op | input | 1 | Opcode works on bytes |
| hint_promote64 | input | 1 | Opcode defaults to 64-bit in mode 2 |
| out_opcode | output | 8 | First opcode byte |
| out_lockrep | output | 2 | Kept lock/repeat prefix |
| out_seg | output | 3 | Kept segment override |
| out_mand | output | 2 | Mandatory prefix code |
| out_rex_present | output | 1 | A REX prefix was kept |
| out_rex_wrxb | output | 4 | REX W, R, X, B bits |
| out_opsize | output | 2 | Effective operand size |
| out_adsize | output | 2 | Effective address size |
| out_err_dup | output | 1 | Repeated legacy prefix |
| out_err_count | output | 1 | Too many legacy prefixes |
| out_err_len | output | 1 | Prefix length limit exceeded |

## Verification
The bench keeps MAX_LEGACY at its default of 4 and lowers MAX_PREFIX_BYTES to 6. With that setting a run of seven REX bytes reaches the length cutoff, and six prefixes followed by an opcode probe the accepted edge. The legacy-count limit is probed on both sides with four and five distinct legacy bytes. Other sequences place 66, F2 and F3 just before the opcode, behind a REX byte, or behind a later prefix, and the bench checks the operand and address sizes in all three modes with and without the downstream hints.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic [1:0] {
        MODE_16  = 2'd0,
        MODE_32  = 2'd1,
        MODE_64  = 2'd2,
        MODE_RSV = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        KIND_OPCODE = 2'd0,
        KIND_LEGACY = 2'd1,
        KIND_REX    = 2'd2
    } kind_e;

    // legacy prefix slot numbers, used for the duplicate mask
    localparam int NUM_LEG = 11;
    localparam logic [3:0] LI_LOCK  = 4'd0;
    localparam logic [3:0] LI_REPNE = 4'd1;
    localparam logic [3:0] LI_REP   = 4'd2;
    localparam logic [3:0] LI_CS    = 4'd3;
    localparam logic [3:0] LI_SS    = 4'd4;
    localparam logic [3:0] LI_DS    = 4'd5;
    localparam logic [3:0] LI_ES    = 4'd6;
    localparam logic [3:0] LI_FS    = 4'd7;
    localparam logic [3:0] LI_GS    = 4'd8;
    localparam logic [3:0] LI_OSZ   = 4'd9;
    localparam logic [3:0] LI_ASZ   = 4'd10;

    // output codings
    localparam logic [1:0] LR_NONE = 2'd0, LR_LOCK = 2'd1, LR_REP = 2'd2, LR_REPNE = 2'd3;
    localparam logic [2:0] SG_NONE = 3'd0, SG_ES = 3'd1, SG_CS = 3'd2, SG_SS = 3'd3,
                           SG_DS = 3'd4, SG_FS = 3'd5, SG_GS = 3'd6;
    localparam logic [1:0] MD_NONE = 2'd0, MD_66 = 2'd1, MD_F3 = 2'd2, MD_F2 = 2'd3;

    typedef struct packed {
        logic [1:0] lockrep;
        logic [2:0] seg;
        logic       osz;
        logic       asz;
    } acc_t;

    // apply one legacy prefix with its ordinary meaning
    function automatic acc_t apply_legacy(acc_t a, logic [3:0] idx, logic is64);
        acc_t r;
        r = a;
        case (idx)
            LI_LOCK:  r.lockrep = LR_LOCK;
            LI_REPNE: r.lockrep = LR_REPNE;
            LI_REP:   r.lockrep = LR_REP;
            LI_CS:    if (!is64) r.seg = SG_CS;
            LI_SS:    if (!is64) r.seg = SG_SS;
            LI_DS:    if (!is64) r.seg = SG_DS;
            LI_ES:    if (!is64) r.seg = SG_ES;
            LI_FS:    r.seg = SG_FS;
            LI_GS:    r.seg = SG_GS;
            LI_OSZ:   r.osz = 1'b1;
            LI_ASZ:   r.asz = 1'b1;
            default:  r = a;
        endcase
        return r;
    endfunction

    // mandatory-prefix code of a slot (none if the slot cannot be mandatory)
    function automatic logic [1:0] mand_code(logic [3:0] idx);
        case (idx)
            LI_OSZ:   return MD_66;
            LI_REP:   return MD_F3;
            LI_REPNE: return MD_F2;
            default:  return MD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic       is64_i,
    output kind_e      kind_o,
    output logic [3:0] idx_o
);

    always_comb begin
        kind_o = KIND_LEGACY;
        idx_o  = 4'd0;
        case (byte_i)
            8'hF0:   idx_o = LI_LOCK;
            8'hF2:   idx_o = LI_REPNE;
            8'hF3:   idx_o = LI_REP;
            8'h2E:   idx_o = LI_CS;
            8'h36:   idx_o = LI_SS;
            8'h3E:   idx_o = LI_DS;
            8'h26:   idx_o = LI_ES;
            8'h64:   idx_o = LI_FS;
            8'h65:   idx_o = LI_GS;
            8'h66:   idx_o = LI_OSZ;
            8'h67:   idx_o = LI_ASZ;
            default: begin
                if (is64_i && byte_i[7:4] == 4'h4) kind_o = KIND_REX;
                else                               kind_o = KIND_OPCODE;
            end
        endcase
    end

endmodule

// File: rtl/pfx_size_resolve.sv
module pfx_size_resolve
    import pfx_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       osz_i,
    input  logic       asz_i,
    input  logic       rex_w_i,
    input  logic       byte_op_i,
    input  logic       promote_i,
    output logic [1:0] opsize_o,
    output logic [1:0] adsize_o
);

    always_comb begin
        unique case (mode_i)
            MODE_16: adsize_o = asz_i ? SZ_32 : SZ_16;
            MODE_64: adsize_o = asz_i ? SZ_32 : SZ_64;
            default: adsize_o = asz_i ? SZ_16 : SZ_32;
        endcase
    end

    always_comb begin
        if (byte_op_i) begin
            opsize_o = SZ_8;
        end else begin
            unique case (mode_i)
                MODE_16: opsize_o = osz_i ? SZ_32 : SZ_16;
                MODE_64: begin
                    if (rex_w_i || promote_i) opsize_o = SZ_64;
                    else                      opsize_o = osz_i ? SZ_16 : SZ_32;
                end
                default: opsize_o = osz_i ? SZ_16 : SZ_32;
            endcase
        end
    end

endmodule

// File: rtl/prefix_size_resolver.sv
module prefix_size_resolver
    import pfx_pkg::*;
#(
    parameter int MAX_LEGACY       = 4,
    parameter int MAX_PREFIX_BYTES = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    output logic       out_valid,
    input  logic       out_ack,
    input  logic       hint_byte_op,
    input  logic       hint_promote64,
    output logic [7:0] out_opcode,
    output logic [1:0] out_lockrep,
    output logic [2:0] out_seg,
    output logic [1:0] out_mand,
    output logic       out_rex_present,
    output logic [3:0] out_rex_wrxb,
    output logic [1:0] out_opsize,
    output logic [1:0] out_adsize,
    output logic       out_err_dup,
    output logic       out_err_count,
    output logic       out_err_len
);

    localparam int CNT_W = $clog2(MAX_PREFIX_BYTES + 1);
    localparam int LEG_W = $clog2(MAX_LEGACY + 2);
    localparam logic [CNT_W-1:0] PFX_LIMIT = CNT_W'(MAX_PREFIX_BYTES);
    localparam logic [LEG_W-1:0] LEG_SAT   = LEG_W'(MAX_LEGACY + 1);

    typedef enum logic {S_SCAN, S_HOLD} state_e;

    state_e st, st_n;

    acc_t               acc, acc_n;
    logic [NUM_LEG-1:0] seen, seen_n;
    logic               dup, dup_n;
    logic [LEG_W-1:0]   leg_cnt, leg_n;
    logic [CNT_W-1:0]   pfx_cnt, pfx_n;
    logic               pend_v, pend_v_n;
    logic [3:0]         pend_i, pend_i_n;
    logic               rex_v, rex_v_n;
    logic [3:0]         rex_b, rex_b_n;
    logic [1:0]         mand, mand_n;
    logic [7:0]         opc, opc_n;
    logic               elen, elen_n;

    logic  is64;
    kind_e kind;
    logic [3:0] idx;

    assign is64 = (mode == MODE_64);

    pfx_classify u_classify (
        .byte_i (in_byte),
        .is64_i (is64),
        .kind_o (kind),
        .idx_o  (idx)
    );

    pfx_size_resolve u_size (
        .mode_i    (mode),
        .osz_i     (acc.osz),
        .asz_i     (acc.asz),
        .rex_w_i   (rex_b[3]),
        .byte_op_i (hint_byte_op),
        .promote_i (hint_promote64),
        .opsize_o  (out_opsize),
        .adsize_o  (out_adsize)
    );

    // next-state and datapath update
    always_comb begin
        st_n     = st;
        acc_n    = acc;
        seen_n   = seen;
        dup_n    = dup;
        leg_n    = leg_cnt;
        pfx_n    = pfx_cnt;
        pend_v_n = pend_v;
        pend_i_n = pend_i;
        rex_v_n  = rex_v;
        rex_b_n  = rex_b;
        mand_n   = mand;
        opc_n    = opc;
        elen_n   = elen;
        unique case (st)
            S_SCAN: begin
                if (in_valid) begin
                    if (kind != KIND_OPCODE && pfx_cnt == PFX_LIMIT) begin
                        // length overflow: drop everything gathered, report
                        acc_n    = '0;
                        seen_n   = '0;
                        dup_n    = 1'b0;
                        leg_n    = '0;
                        pfx_n    = '0;
                        pend_v_n = 1'b0;
                        pend_i_n = '0;
                        rex_v_n  = 1'b0;
                        rex_b_n  = '0;
                        mand_n   = MD_NONE;
                        opc_n    = in_byte;
                        elen_n   = 1'b1;
                        st_n     = S_HOLD;
                    end else if (kind == KIND_LEGACY) begin
                        pfx_n       = pfx_cnt + 1'b1;
                        dup_n       = dup | seen[idx];
                        seen_n[idx] = 1'b1;
                        if (leg_cnt != LEG_SAT) leg_n = leg_cnt + 1'b1;
                        if (pend_v) acc_n = apply_legacy(acc, pend_i, is64);
                        pend_v_n    = 1'b1;
                        pend_i_n    = idx;
                        rex_v_n     = 1'b0;
                        rex_b_n     = '0;
                    end else if (kind == KIND_REX) begin
                        pfx_n   = pfx_cnt + 1'b1;
                        rex_v_n = 1'b1;
                        rex_b_n = in_byte[3:0];
                    end else begin
                        opc_n = in_byte;
                        if (pend_v) begin
                            if (mand_code(pend_i) != MD_NONE) mand_n = mand_code(pend_i);
                            else                              acc_n  = apply_legacy(acc, pend_i, is64);
                        end
                        pend_v_n = 1'b0;
                        st_n     = S_HOLD;
                    end
                end
            end
            S_HOLD: begin
                if (out_ack) begin
                    acc_n    = '0;
                    seen_n   = '0;
                    dup_n    = 1'b0;
                    leg_n    = '0;
                    pfx_n    = '0;
                    pend_v_n = 1'b0;
                    pend_i_n = '0;
                    rex_v_n  = 1'b0;
                    rex_b_n  = '0;
                    mand_n   = MD_NONE;
                    opc_n    = '0;
                    elen_n   = 1'b0;
                    st_n     = S_SCAN;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_SCAN;
        else        st <= st_n;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            seen    <= '0;
            dup     <= 1'b0;
            leg_cnt <= '0;
            pfx_cnt <= '0;
            pend_v  <= 1'b0;
            pend_i  <= '0;
            rex_v   <= 1'b0;
            rex_b   <= '0;
            mand    <= MD_NONE;
            opc     <= '0;
            elen    <= 1'b0;
        end else begin
            acc     <= acc_n;
            seen    <= seen_n;
            dup     <= dup_n;
            leg_cnt <= leg_n;
            pfx_cnt <= pfx_n;
            pend_v  <= pend_v_n;
            pend_i  <= pend_i_n;
            rex_v   <= rex_v_n;
            rex_b   <= rex_b_n;
            mand    <= mand_n;
            opc     <= opc_n;
            elen    <= elen_n;
        end
    end

    assign in_ready        = (st == S_SCAN);
    assign out_valid       = (st == S_HOLD);
    assign out_opcode      = opc;
    assign out_lockrep     = acc.lockrep;
    assign out_seg         = acc.seg;
    assign out_mand        = mand;
    assign out_rex_present = rex_v;
    assign out_rex_wrxb    = rex_b;
    assign out_err_dup     = dup;
    assign out_err_count   = (leg_cnt == LEG_SAT);
    assign out_err_len     = elen;

    // R1
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ack |=> out_valid && $stable(out_opcode) && $stable(out_mand)
                                  && $stable(out_rex_wrxb) && $stable(out_seg));
    // R1
    ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ack |=> in_ready && !out_valid);
    // R4
    seg_drop64_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode == MODE_64 |-> (out_seg == SG_NONE || out_seg == SG_FS || out_seg == SG_GS));
    // R6
    rex_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_rex_present |-> mode == MODE_64);
    // R9
    adsize_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode != MODE_64 |-> out_adsize != SZ_64);
    // R10
    byteop_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && hint_byte_op |-> out_opsize == SZ_8);
    // R13
    len_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err_len |-> out_mand == MD_NONE && !out_rex_present && out_seg == SG_NONE);

endmodule

// File: tb/tb_prefix_size_resolver.sv
module tb_prefix_size_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic       out_ack = 1'b0;
    logic       hint_byte_op = 1'b0;
    logic       hint_promote64 = 1'b0;
    logic [7:0] out_opcode;
    logic [1:0] out_lockrep;
    logic [2:0] out_seg;
    logic [1:0] out_mand;
    logic       out_rex_present;
    logic [3:0] out_rex_wrxb;
    logic [1:0] out_opsize;
    logic [1:0] out_adsize;
    logic       out_err_dup;
    logic       out_err_count;
    logic       out_err_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prefix_size_resolver #(.MAX_LEGACY(4), .MAX_PREFIX_BYTES(6)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_ack(out_ack),
        .hint_byte_op(hint_byte_op), .hint_promote64(hint_promote64),
        .out_opcode(out_opcode), .out_lockrep(out_lockrep), .out_seg(out_seg),
        .out_mand(out_mand), .out_rex_present(out_rex_present), .out_rex_wrxb(out_rex_wrxb),
        .out_opsize(out_opsize), .out_adsize(out_adsize),
        .out_err_dup(out_err_dup), .out_err_count(out_err_count), .out_err_len(out_err_len)
    );

    typedef struct {
        string       req;
        logic [26:0] vec;
        bit          hb;
        bit          hp;
    } exp_t;

    exp_t sb[$];

    function automatic logic [26:0] mk(logic [7:0] opc, logic [1:0] lr, logic [2:0] seg,
                                       logic [1:0] md, logic rp, logic [3:0] wrxb,
                                       logic [1:0] osz, logic [1:0] asz,
                                       logic dp, logic cn, logic ln);
        return {opc, lr, seg, md, rp, wrxb, osz, asz, dp, cn, ln};
    endfunction

    function automatic logic [26:0] observed();
        return {out_opcode, out_lockrep, out_seg, out_mand, out_rex_present, out_rex_wrxb,
                out_opsize, out_adsize, out_err_dup, out_err_count, out_err_len};
    endfunction

    task automatic check(string req, logic [26:0] got, logic [26:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, want);
        end
    endtask

    // driver: queue the expectation, then feed the bytes (byte 0 in bits 7:0)
    task automatic run(string req, logic [1:0] m, int n, logic [63:0] bytes,
                       logic [26:0] want, bit hb, bit hp);
        exp_t e;
        e.req = req; e.vec = want; e.hb = hb; e.hp = hp;
        sb.push_back(e);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        mode = m;
        for (int i = 0; i < n; i++) begin
            in_byte  = bytes[8*i +: 8];
            in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // monitor: pop and compare each record, recheck it later, then acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (out_valid) begin
                if (sb.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R1: got unexpected record %h expected none", observed());
                    out_ack = 1'b1;
                    @(negedge clk);
                    out_ack = 1'b0;
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    hint_byte_op   = e.hb;
                    hint_promote64 = e.hp;
                    #1;
                    check(e.req, observed(), e.vec);
                    repeat (2) @(negedge clk);
                    #1;
                    if (!out_valid) check("R1 hold", 27'h0, 27'h1);
                    else            check("R1 hold", observed(), e.vec);
                    out_ack = 1'b1;
                    @(negedge clk);
                    out_ack = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1: watchdog expired, got no completion expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset", {25'h0, in_ready, out_valid}, {25'h0, 1'b1, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);

        // R7 plain opcode, 16-bit
        run("R7", 2'd0, 1, 64'h89, mk(8'h89, 0, 0, 0, 0, 4'h0, 1, 1, 0, 0, 0), 0, 0);
        // R9 66 and 67 applied in 16-bit
        run("R9", 2'd0, 3, 64'h896766, mk(8'h89, 0, 0, 0, 0, 4'h0, 2, 2, 0, 0, 0), 0, 0);
        // R5 66 directly before opcode is mandatory
        run("R5", 2'd1, 2, 64'h0F66, mk(8'h0F, 0, 0, 1, 0, 4'h0, 2, 2, 0, 0, 0), 0, 0);
        // R3 F3 then CS, 32-bit
        run("R3", 2'd1, 3, 64'hA42EF3, mk(8'hA4, 2, 2, 0, 0, 4'h0, 2, 2, 0, 0, 0), 0, 0);
        // R2 lock then repne: last wins, DS kept
        run("R2", 2'd1, 4, 64'h8B3EF2F0, mk(8'h8B, 3, 4, 0, 0, 4'h0, 2, 2, 0, 0, 0), 0, 0);
        // R4 CS/ES dropped, FS kept in 64-bit
        run("R4", 2'd2, 4, 64'h8B26642E, mk(8'h8B, 0, 5, 0, 0, 4'h0, 2, 3, 0, 0, 0), 0, 0);
        // R8 REX.W gives 64
        run("R8", 2'd2, 2, 64'h8948, mk(8'h89, 0, 0, 0, 1, 4'h8, 3, 3, 0, 0, 0), 0, 0);
        // R6 R10 bare REX 40 still present, byte op gives 8
        run("R6 R10", 2'd2, 2, 64'h8840, mk(8'h88, 0, 0, 0, 1, 4'h0, 0, 3, 0, 0, 0), 1, 0);
        // R8 66 applied but ignored under REX.W
        run("R8", 2'd2, 4, 64'h89482E66, mk(8'h89, 0, 0, 0, 1, 4'h8, 3, 3, 0, 0, 0), 0, 0);
        // R8 R9 66 and 67 in 64-bit
        run("R8 R9", 2'd2, 3, 64'h896766, mk(8'h89, 0, 0, 0, 0, 4'h0, 1, 2, 0, 0, 0), 0, 0);
        // R6 REX followed by legacy bytes is discarded
        run("R6", 2'd2, 4, 64'h012E664C, mk(8'h01, 0, 0, 0, 0, 4'h0, 1, 3, 0, 0, 0), 0, 0);
        // R6 byte 40 is an opcode in 32-bit
        run("R6", 2'd1, 1, 64'h40, mk(8'h40, 0, 0, 0, 0, 4'h0, 2, 2, 0, 0, 0), 0, 0);
        // R8 promote hint overrides 66
        run("R8", 2'd2, 3, 64'h506766, mk(8'h50, 0, 0, 0, 0, 4'h0, 3, 2, 0, 0, 0), 0, 1);
        // R11 repeated CS
        run("R11", 2'd1, 3, 64'h8B2E2E, mk(8'h8B, 0, 2, 0, 0, 4'h0, 2, 2, 1, 0, 0), 0, 0);
        // R12 five legacy bytes
        run("R12", 2'd0, 6, 64'h8B67663E2EF0, mk(8'h8B, 1, 4, 0, 0, 4'h0, 2, 2, 0, 1, 0), 0, 0);
        // R12 exactly four legacy bytes, last 66 mandatory
        run("R12 R5", 2'd0, 5, 64'h8B66672EF0, mk(8'h8B, 1, 2, 1, 0, 4'h0, 1, 2, 0, 0, 0), 0, 0);
        // R5 F2 mandatory across a REX
        run("R5", 2'd2, 3, 64'h0F4DF2, mk(8'h0F, 0, 0, 3, 1, 4'hD, 3, 3, 0, 0, 0), 0, 0);
        // R13 exactly six prefixes accepted
        run("R13", 2'd2, 7, 64'h89414040404040, mk(8'h89, 0, 0, 0, 1, 4'h1, 2, 3, 0, 0, 0), 0, 0);
        // R13 seventh prefix triggers length error
        run("R13", 2'd2, 7, 64'h40404040404040, mk(8'h40, 0, 0, 0, 0, 4'h0, 2, 3, 0, 0, 1), 0, 0);
        // R13 clean restart afterwards
        run("R13", 2'd2, 1, 64'h89, mk(8'h89, 0, 0, 0, 0, 4'h0, 2, 3, 0, 0, 0), 0, 0);

        while (sb.size() != 0 || !in_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule